// File: doc/BRIEF.md
# Profile-Selected Phase Accumulator

This block is the digital heart of a synthesised clock source. It keeps eight profiles. Each profile pairs a 48-bit frequency tuning word with a 14-bit edge delay word. A 3-bit select input chooses which profile drives the output. On every clock the phase accumulator adds the active profile's tuning word. The same profile's delay word appears as a static offset on `delay_o`, where a later edge-delay stage applies it to both clock edges.

The tuning word and the delay word are captured together from one profile into a single pair register. A change of profile therefore moves both words on the same clock edge, and the output never pairs the frequency of one profile with the delay of another. The profile words are loaded through a plain write port that takes an address and data. The upper bits of the accumulator are exported as a phase word for a phase-to-amplitude stage that sits outside this block.

Top module: `dds_profile_core`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` into profile `wr_addr_i[3:1]`. If `wr_addr_i[0]` is 0, all 48 bits go to the tuning word. If `wr_addr_i[0]` is 1, bits [13:0] go to the delay word.
- R2: While `rst_n` is low at a rising edge (synchronous reset), the accumulator, every profile word, the select pipeline and both outputs clear to zero.
- R3: The active profile is the binary value of `sel_i`, with `sel_i[0]` as the least significant bit. `sel_i` passes through two flops. After `sel_i` changes, `delay_o` shows the new profile's delay word from the third rising edge onward.
- R4: On every rising edge out of reset, the accumulator adds the active tuning word modulo 2^48.
- R5: `phase_o` equals the accumulator's upper 14 bits, bits [47:34].
- R6: The tuning word and the delay word always come from the same profile, and both switch to a new profile on the same edge. The first accumulator step that uses the new tuning word is the edge after `delay_o` changes.
- R7: A write to the active profile reaches `delay_o`, or the accumulator step, one edge after the write edge.
- R8: A write to a profile that is not active leaves `delay_o` and the phase progression unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 3 | Profile select, bit 0 is the LSB |
| wr_en_i | input | 1 | Profile write strobe |
| wr_addr_i | input | 4 | Bits [3:1] give the profile, bit 0 gives the word kind (0 = tuning, 1 = delay) |
| wr_data_i | input | 48 | Write data |
| phase_o | output | 14 | Upper bits of the accumulator |
| delay_o | output | 14 | Delay word of the active profile |

## Verification
The hardest case to reach from the ports is a profile change that lands while the pipeline is still busy with an earlier change or with a write. If both words were not taken from one profile in one step, a mixed pair would show up for a single cycle and then vanish. The stimulus toggles `sel_i` every cycle, and also writes to the profile that is about to become active while its select value is still in the two flops. A cycle-exact reference model checks every cycle, so a one-cycle mismatch between the step size and the delay word cannot go unseen.

// File: rtl/dds_prof_pkg.sv
// Package: shared types for the profile-selected phase accumulator.
// Assumes: address bit 0 encodes which word of a profile a write targets.
package dds_prof_pkg;

    typedef enum logic {
        WK_TUNE  = 1'b0,
        WK_DELAY = 1'b1
    } word_kind_e;

endpackage

// File: rtl/dds_sel_sync.sv
// Module: dds_sel_sync
// Registers the external profile select through two flops.
// Assumes: sel_i is driven in the clk domain or changes slowly; reset is synchronous.
module dds_sel_sync #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] sel_q
);

    logic [SEL_W-1:0] stage1_q;
    logic [SEL_W-1:0] stage2_q;

    // Purpose: two-stage shift of the select value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= sel_i;
            stage2_q <= stage1_q;
        end
    end

    assign sel_q = stage2_q;

    // R3: first stage follows the pin one edge later
    a_r3_stage1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage1_q == $past(sel_i));

    // R3: second stage follows the first one edge later
    a_r3_stage2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage2_q == $past(stage1_q));

endmodule

// File: rtl/dds_profile_bank.sv
// Module: dds_profile_bank
// Holds the tuning and delay words of every profile, and loads the selected
// profile's two words into one pair register so they always move together.
// Assumes: rd_sel already registered; writes and reads share one clock.
module dds_profile_bank
    import dds_prof_pkg::*;
#(
    parameter int NUM_PROF = 8,
    parameter int FTW_W    = 48,
    parameter int DLY_W    = 14,
    localparam int SEL_W   = $clog2(NUM_PROF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_prof,
    input  word_kind_e       wr_kind,
    input  logic [FTW_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [FTW_W-1:0] act_ftw,
    output logic [DLY_W-1:0] act_dly
);

    logic [FTW_W-1:0] ftw_mem [NUM_PROF];
    logic [DLY_W-1:0] dly_mem [NUM_PROF];
    logic [SEL_W-1:0] act_idx;
    logic [FTW_W-1:0] ftw_q;
    logic [DLY_W-1:0] dly_q;

    // Purpose: store profile words on write, clear all on reset.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PROF; p++) begin
            if (!rst_n) begin
                ftw_mem[p] <= '0;
                dly_mem[p] <= '0;
            end else if (wr_en && wr_prof == SEL_W'(p)) begin
                if (wr_kind == WK_TUNE) begin
                    ftw_mem[p] <= wr_data;
                end else begin
                    dly_mem[p] <= wr_data[DLY_W-1:0];
                end
            end
        end
    end

    // Purpose: capture both words of one profile in a single step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_q   <= '0;
            dly_q   <= '0;
            act_idx <= '0;
        end else begin
            ftw_q   <= ftw_mem[rd_sel];
            dly_q   <= dly_mem[rd_sel];
            act_idx <= rd_sel;
        end
    end

    assign act_ftw = ftw_q;
    assign act_dly = dly_q;

    // R1: a tuning write lands in the addressed profile
    a_r1_tune_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_TUNE) |=> ftw_mem[$past(wr_prof)] == $past(wr_data));

    // R1: a delay write lands in the addressed profile
    a_r1_delay_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_DELAY) |=> dly_mem[$past(wr_prof)] == $past(wr_data[DLY_W-1:0]));

    // R6, R8: same profile held and not rewritten means the pair holds still
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_sel == act_idx &&
         !($past(wr_en) && $past(wr_prof) == act_idx))
        |=> ($stable(ftw_q) && $stable(dly_q)));

    // R2: reset clears the active pair
    a_r2_pair_clear: assert property (@(posedge clk)
        !rst_n |=> (ftw_q == '0 && dly_q == '0));

endmodule

// File: rtl/dds_phase_acc.sv
// Module: dds_phase_acc
// Phase accumulator that wraps modulo 2^ACC_W and exports its upper bits.
// Assumes: step is a registered tuning word; reset is synchronous.
module dds_phase_acc #(
    parameter int ACC_W   = 48,
    parameter int PHASE_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   step,
    output logic [PHASE_W-1:0] phase
);

    logic [ACC_W-1:0] acc_q;

    // Purpose: advance the phase by the step each clock, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + step;
        end
    end

    assign phase = acc_q[ACC_W-1 -: PHASE_W];

    // R4: each edge adds the previous step modulo 2^ACC_W
    a_r4_acc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> acc_q == ACC_W'($past(acc_q) + $past(step)));

    // R2: reset clears the accumulator
    a_r2_acc_clear: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0);

endmodule

// File: rtl/dds_profile_core.sv
// Module: dds_profile_core (top)
// Eight-profile phase accumulator with a paired delay word output.
// Assumes: one clock domain; synchronous active-low reset.
module dds_profile_core
    import dds_prof_pkg::*;
#(
    parameter int NUM_PROF = 8,
    parameter int FTW_W    = 48,
    parameter int DLY_W    = 14,
    parameter int PHASE_W  = 14,
    localparam int SEL_W   = $clog2(NUM_PROF),
    localparam int ADDR_W  = SEL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [FTW_W-1:0]   wr_data_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [DLY_W-1:0]   delay_o
);

    logic [SEL_W-1:0] sel_q;
    logic [FTW_W-1:0] act_ftw;
    logic [DLY_W-1:0] act_dly;
    word_kind_e       wr_kind;

    assign wr_kind = word_kind_e'(wr_addr_i[0]);

    dds_sel_sync #(.SEL_W(SEL_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel_i),
        .sel_q (sel_q)
    );

    dds_profile_bank #(
        .NUM_PROF (NUM_PROF),
        .FTW_W    (FTW_W),
        .DLY_W    (DLY_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_prof (wr_addr_i[ADDR_W-1:1]),
        .wr_kind (wr_kind),
        .wr_data (wr_data_i),
        .rd_sel  (sel_q),
        .act_ftw (act_ftw),
        .act_dly (act_dly)
    );

    dds_phase_acc #(
        .ACC_W   (FTW_W),
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (act_ftw),
        .phase (phase_o)
    );

    assign delay_o = act_dly;

    // R2: reset clears both outputs
    a_r2_out_clear: assert property (@(posedge clk)
        !rst_n |=> (phase_o == '0 && delay_o == '0));

endmodule

// File: tb/test_dds_profile_core.sv
module test_dds_profile_core;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [47:0] wr_data_i = '0;
    logic [13:0] phase_o;
    logic [13:0] delay_o;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [47:0] b_ftw [8];
    logic [13:0] b_dly [8];
    logic [2:0]  m_s1, m_s2;
    logic [47:0] m_ftw, m_acc;
    logic [13:0] m_dly;

    logic [13:0] q_ph [$];
    logic [13:0] q_dl [$];
    string       q_tag [$];

    always #(CLK_P/2) clk = ~clk;

    dds_profile_core i_dds_profile_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .phase_o   (phase_o),
        .delay_o   (delay_o)
    );

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            b_ftw[i] = '0;
            b_dly[i] = '0;
        end
        m_s1 = '0; m_s2 = '0; m_ftw = '0; m_acc = '0; m_dly = '0;
    endtask

    // driver: apply inputs for one edge, push expected post-edge outputs
    task automatic step(input logic [2:0] s, input logic we, input logic [3:0] a,
                        input logic [47:0] d, input string tag);
        logic [47:0] n_acc, n_ftw;
        logic [13:0] n_dly;
        sel_i = s; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
        n_acc = m_acc + m_ftw;
        n_ftw = b_ftw[m_s2];
        n_dly = b_dly[m_s2];
        m_s2 = m_s1;
        m_s1 = s;
        if (we) begin
            if (a[0]) b_dly[a[3:1]] = d[13:0];
            else      b_ftw[a[3:1]] = d;
        end
        m_acc = n_acc; m_ftw = n_ftw; m_dly = n_dly;
        q_ph.push_back(n_acc[47:34]);
        q_dl.push_back(n_dly);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input logic [2:0] s, input int n, input string tag);
        for (int k = 0; k < n; k++) step(s, 1'b0, 4'h0, 48'h0, tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [2:0] p, input logic kind,
                      input logic [47:0] d, input string tag);
        step(s, 1'b1, {p, kind}, d, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en_i = 1'b0;
        sel_i = '0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (phase_o !== 14'h0 || delay_o !== 14'h0) begin
            n_bad++;
            $display("FAIL R2 reset outputs: phase=%h delay=%h expected 0 0", phase_o, delay_o);
        end
        model_clear();
        rst_n = 1'b1;
    endtask

    // monitor: compare once per edge, a quarter period after it
    always @(posedge clk) begin
        #(CLK_P/4);
        if (q_ph.size() > 0) begin
            logic [13:0] ep, ed;
            string t;
            ep = q_ph.pop_front();
            ed = q_dl.pop_front();
            t  = q_tag.pop_front();
            n_chk += 2;
            if (phase_o !== ep) begin
                n_bad++;
                $display("FAIL %s phase: actual=%h expected=%h", t, phase_o, ep);
            end
            if (delay_o !== ed) begin
                n_bad++;
                $display("FAIL %s delay: actual=%h expected=%h", t, delay_o, ed);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();
        idle(3'd0, 4, "R2");
        // R1: load all profiles while profile 7 is active (it is written last)
        for (int p = 0; p < 8; p++) begin
            wr(3'd7, 3'(p), 1'b0, 48'h0A3D_70A3_D70A * (p + 1) + 48'h1357, "R1");
            wr(3'd7, 3'(p), 1'b1, 48'(14'h0111 * (p + 1) + p), "R1");
        end
        idle(3'd7, 6, "R4");
        // R3 and R5: sweep the select through every profile, holding each
        for (int p = 0; p < 8; p++) idle(3'(p), 6, "R3");
        // R6: toggle the select every cycle
        for (int k = 0; k < 24; k++) idle(3'(k * 5), 1, "R6");
        idle(3'd2, 5, "R6");
        // R4: wrap with a near-full tuning word
        wr(3'd2, 3'd2, 1'b0, 48'hFFFF_FFFF_FFF3, "R4");
        idle(3'd2, 12, "R4");
        // R7: writes to the active profile
        wr(3'd2, 3'd2, 1'b1, 48'h0000_0000_2ABC, "R7");
        idle(3'd2, 3, "R7");
        wr(3'd2, 3'd2, 1'b0, 48'h1234_5678_9ABC, "R7");
        idle(3'd2, 4, "R7");
        // R8: writes to inactive profiles
        wr(3'd2, 3'd5, 1'b1, 48'h0000_0000_3FFF, "R8");
        wr(3'd2, 3'd6, 1'b0, 48'h7777_0000_0001, "R8");
        idle(3'd2, 4, "R8");
        // R6: write the profile whose select value is still in the flops
        idle(3'd4, 1, "R6");
        wr(3'd4, 3'd4, 1'b1, 48'h0000_0000_0ACE, "R6");
        wr(3'd4, 3'd4, 1'b0, 48'h0F0F_0F0F_0F0F, "R6");
        idle(3'd4, 6, "R6");
        // R2: second reset clears profile contents
        @(negedge clk);
        q_ph.delete(); q_dl.delete(); q_tag.delete();
        do_reset();
        for (int p = 0; p < 8; p++) idle(3'(p), 3, "R2");
        idle(3'd0, 3, "R2");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule